// File: doc/BRIEF.md
# Encoder Loop Pacing and Edge Interval Timer

This block supplies the timing functions that sit beside a quadrature encoder decoder. A loop pacer built from a prescaler and a reloading down-counter produces a periodic interrupt pulse that can schedule speed and position control loops. An edge interval timer counts the system clocks spanned by a programmable number of encoder edges, so that firmware can estimate velocity accurately when the shaft turns slowly and edges are far apart.

The encoder inputs A and B arrive already synchronized to the clock. Any sample in which exactly one of them changes is an encoder edge. A sample in which both change at once is a sequence fault: it sets a sticky fault flag, pulses a fault interrupt and is not counted as an edge. Software configures the block through a simple write port. Each measured interval leaves on a valid/ready stream. The stream holds a result until the consumer accepts it. While a result waits, any newer result is discarded so that the held data never changes under back-pressure.

Top module: `enc_timing_unit`

## Requirements
- R1: After reset, loop_irq, fault_irq, fault_flag and meas_valid are 0 and loop_count is 0; the reload value, the prescale and the edge span all reset to 0.
- R2: A write to address 0 stores wr_data[15:0] as the reload value, loads it into loop_count and restarts the prescaler. loop_count decrements once per prescale period. When the prescale period ends with loop_count at 0, loop_count reloads and loop_irq pulses. The first pulse comes exactly (reload+1)*(prescale+1) clocks after the write, and later pulses follow at the same interval.
- R3: A write to address 1 stores wr_data[15:0] as the prescale value and restarts the prescaler; a prescale of S gives a prescale period of S+1 clocks.
- R4: While the reload value is 0 the loop pacer is stopped and loop_irq stays 0.
- R5: loop_irq is high for exactly one clock per timeout.
- R6: A write to address 2 stores wr_data[7:0] as the edge span N (1 to 255) and opens a new measurement window. When the N-th edge of a window is seen, the clocks elapsed since the window opened are emitted on meas_data, and the next window opens in the same clock.
- R7: An edge span of 0 disables measurement: edges produce no result.
- R8: The elapsed-clock count saturates at 2^MEAS_W-1 instead of wrapping.
- R9: meas_valid stays high with meas_data unchanged until meas_ready is seen high. A result completed while an earlier result is still waiting is discarded.
- R10: A sample in which A and B both change sets fault_flag and pulses fault_irq for one clock, and it does not count as an edge.
- R11: Writing address 3 with wr_data[0]=1 clears fault_flag. Writing it with wr_data[0]=0 has no effect, and a new fault in the same clock as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a | input | 1 | Synchronized encoder channel A |
| enc_b | input | 1 | Synchronized encoder channel B |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 reload, 1 prescale, 2 edge span, 3 fault clear |
| wr_data | input | LOOP_W (16) | Register write data |
| loop_irq | output | 1 | One-clock loop timeout pulse |
| loop_count | output | LOOP_W (16) | Current loop down-counter value |
| fault_irq | output | 1 | One-clock sequence fault pulse |
| fault_flag | output | 1 | Sticky sequence fault status |
| meas_valid | output | 1 | Interval result available |
| meas_ready | input | 1 | Consumer accepts the interval result |
| meas_data | output | MEAS_W (32) | Clocks spanned by the last N edges |

## Verification
On every clock, the assertions check that a held result stays stable under back-pressure, that loop_irq never lasts two clocks and stays low while the reload value is 0, that a timeout leaves the counter at its reload value, that the elapsed count never wraps past its ceiling, and that the fault flag persists until cleared. The exact loop intervals for several prescale and reload pairs can only be shown by the bench scenarios. The same holds for the measured interval values for several spans and edge spacings, the discarding of a result completed during back-pressure, the exclusion of faults from the edge count, and the clear-write behaviour.

// File: rtl/enc_tmr_pkg.sv
package enc_tmr_pkg;
  typedef enum logic [1:0] {
    ADDR_RELOAD   = 2'd0,
    ADDR_PRESCALE = 2'd1,
    ADDR_SPAN     = 2'd2,
    ADDR_FAULTCLR = 2'd3
  } reg_addr_e;

  localparam int DEF_LOOP_W = 16;
  localparam int DEF_MEAS_W = 32;
  localparam int DEF_SPAN_W = 8;
endpackage

// File: rtl/enc_loop_pacer.sv
module enc_loop_pacer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reload_we,
  input  logic         scale_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] count_o,
  output logic         timeout_o
);
  logic [W-1:0] reload_q, scale_q, pre_q, cnt_q;
  logic         tick, running;

  assign running = (reload_q != '0);
  assign tick    = (pre_q == scale_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q  <= '0;
      scale_q   <= '0;
      pre_q     <= '0;
      cnt_q     <= '0;
      timeout_o <= 1'b0;
    end else begin
      timeout_o <= 1'b0;
      if (reload_we) begin
        reload_q <= wdata;
        cnt_q    <= wdata;
        pre_q    <= '0;
      end else if (scale_we) begin
        scale_q  <= wdata;
        pre_q    <= '0;
      end else if (running) begin
        if (tick) begin
          pre_q <= '0;
          if (cnt_q == '0) begin
            cnt_q     <= reload_q;
            timeout_o <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end
  end

  assign count_o = cnt_q;

  a_r2_reload_on_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (cnt_q == reload_q));
  a_r4_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_q == '0) |=> !timeout_o);
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);
endmodule

// File: rtl/enc_seq_check.sv
module enc_seq_check (
  input  logic clk,
  input  logic rst_n,
  input  logic enc_a,
  input  logic enc_b,
  input  logic clr,
  output logic edge_o,
  output logic fault_irq,
  output logic fault_flag
);
  logic [1:0] prev_q;
  logic       primed_q;
  logic [1:0] diff;
  logic       bad;

  assign diff   = prev_q ^ {enc_a, enc_b};
  assign edge_o = primed_q && (diff == 2'b01 || diff == 2'b10);
  assign bad    = primed_q && (diff == 2'b11);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q     <= 2'b00;
      primed_q   <= 1'b0;
      fault_irq  <= 1'b0;
      fault_flag <= 1'b0;
    end else begin
      prev_q    <= {enc_a, enc_b};
      primed_q  <= 1'b1;
      fault_irq <= bad;
      if (bad)      fault_flag <= 1'b1;
      else if (clr) fault_flag <= 1'b0;
    end
  end

  a_r10_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    fault_irq |-> fault_flag);
  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_flag && !clr) |=> fault_flag);
endmodule

// File: rtl/enc_edge_timer.sv
module enc_edge_timer #(
  parameter int MEAS_W = 32,
  parameter int SPAN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              edge_i,
  input  logic              span_we,
  input  logic [SPAN_W-1:0] span_wd,
  output logic              meas_valid,
  input  logic              meas_ready,
  output logic [MEAS_W-1:0] meas_data
);
  localparam logic [MEAS_W-1:0] CEIL = {MEAS_W{1'b1}};

  logic [SPAN_W-1:0] span_q, ecnt_q;
  logic [MEAS_W-1:0] cyc_q, cyc_nx;
  logic              enabled, hit, restart, slot_free;

  assign enabled   = (span_q != '0);
  assign cyc_nx    = (cyc_q == CEIL) ? CEIL : cyc_q + 1'b1;
  assign hit       = enabled && !span_we && edge_i &&
                     ({1'b0, ecnt_q} + 1'b1 == {1'b0, span_q});
  assign restart   = span_we || !enabled || hit;
  assign slot_free = !meas_valid || meas_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      span_q <= '0;
      ecnt_q <= '0;
      cyc_q  <= '0;
    end else begin
      if (span_we) span_q <= span_wd;
      if (restart) begin
        ecnt_q <= '0;
        cyc_q  <= '0;
      end else begin
        cyc_q <= cyc_nx;
        if (edge_i) ecnt_q <= ecnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meas_valid <= 1'b0;
      meas_data  <= '0;
    end else begin
      if (meas_valid && meas_ready) meas_valid <= 1'b0;
      if (hit && slot_free) begin
        meas_valid <= 1'b1;
        meas_data  <= cyc_nx;
      end
    end
  end

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid && !meas_ready) |=> (meas_valid && $stable(meas_data)));
  a_r7_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!enabled && !meas_valid) |=> !meas_valid);
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == CEIL && !restart) |=> (cyc_q == CEIL));
endmodule

// File: rtl/enc_timing_unit.sv
module enc_timing_unit
  import enc_tmr_pkg::*;
#(
  parameter int LOOP_W = DEF_LOOP_W,
  parameter int MEAS_W = DEF_MEAS_W,
  parameter int SPAN_W = DEF_SPAN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [LOOP_W-1:0] wr_data,
  output logic              loop_irq,
  output logic [LOOP_W-1:0] loop_count,
  output logic              fault_irq,
  output logic              fault_flag,
  output logic              meas_valid,
  input  logic              meas_ready,
  output logic [MEAS_W-1:0] meas_data
);
  logic we_reload, we_scale, we_span, fault_clr, edge_seen;

  assign we_reload = wr_en && (reg_addr_e'(wr_addr) == ADDR_RELOAD);
  assign we_scale  = wr_en && (reg_addr_e'(wr_addr) == ADDR_PRESCALE);
  assign we_span   = wr_en && (reg_addr_e'(wr_addr) == ADDR_SPAN);
  assign fault_clr = wr_en && (reg_addr_e'(wr_addr) == ADDR_FAULTCLR) && wr_data[0];

  enc_loop_pacer #(.W(LOOP_W)) u_pacer (
    .clk       (clk),
    .rst_n     (rst_n),
    .reload_we (we_reload),
    .scale_we  (we_scale),
    .wdata     (wr_data),
    .count_o   (loop_count),
    .timeout_o (loop_irq)
  );

  enc_seq_check u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .enc_a      (enc_a),
    .enc_b      (enc_b),
    .clr        (fault_clr),
    .edge_o     (edge_seen),
    .fault_irq  (fault_irq),
    .fault_flag (fault_flag)
  );

  enc_edge_timer #(.MEAS_W(MEAS_W), .SPAN_W(SPAN_W)) u_meas (
    .clk        (clk),
    .rst_n      (rst_n),
    .edge_i     (edge_seen),
    .span_we    (we_span),
    .span_wd    (wr_data[SPAN_W-1:0]),
    .meas_valid (meas_valid),
    .meas_ready (meas_ready),
    .meas_data  (meas_data)
  );
endmodule

// File: tb/sim_enc_timing_unit.sv
`timescale 1ns/1ps
module sim_enc_timing_unit;
  localparam int MW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enc_a = 1'b0, enc_b = 1'b0, wr_en = 1'b0, meas_ready = 1'b1;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic loop_irq, fault_irq, fault_flag, meas_valid;
  logic [15:0] loop_count;
  logic [MW-1:0] meas_data;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int exp_q[$];
  bit next_is_a = 1'b1;

  always #2.5 clk = ~clk;

  enc_timing_unit #(.MEAS_W(MW)) u0 (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .loop_irq(loop_irq), .loop_count(loop_count),
    .fault_irq(fault_irq), .fault_flag(fault_flag),
    .meas_valid(meas_valid), .meas_ready(meas_ready), .meas_data(meas_data)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic step(input int gap);
    repeat (gap) @(negedge clk);
    if (next_is_a) enc_a = ~enc_a; else enc_b = ~enc_b;
    next_is_a = ~next_is_a;
  endtask

  task automatic gap_to_irq(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!loop_irq && n < 1000);
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk); #1;
    if (meas_valid && meas_ready) begin
      if (exp_q.size() == 0) check("R6 unexpected result", meas_data, -1);
      else check("R6 measured interval", meas_data, exp_q.pop_front());
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, hits;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1
    check("R1 loop_irq", loop_irq, 0);
    check("R1 fault", {fault_irq, fault_flag}, 0);
    check("R1 meas_valid", meas_valid, 0);
    check("R1 loop_count", loop_count, 0);

    // R2 R3: prescale 2, reload 3 -> 12 clocks
    wr(2'd1, 16'd2);
    wr(2'd0, 16'd3);
    check("R2 count loaded", loop_count, 3);
    gap_to_irq(n); check("R2 R3 first interval", n, 12);
    @(negedge clk); n = 1; check("R5 pulse width", loop_irq, 0);
    while (!loop_irq && n < 1000) begin @(negedge clk); n++; end
    check("R2 R3 repeat interval", n, 12);
    // R4
    wr(2'd0, 16'd0);
    hits = 0;
    repeat (40) begin @(negedge clk); if (loop_irq) hits++; end
    check("R4 stopped pacer irqs", hits, 0);
    // R3 with prescale 0, reload 5 -> 6 clocks
    wr(2'd1, 16'd0);
    wr(2'd0, 16'd5);
    gap_to_irq(n); check("R3 prescale 0 interval", n, 6);
    gap_to_irq(n); check("R2 prescale 0 repeat", n, 6);
    wr(2'd0, 16'd0);

    // R6: span 3
    wr(2'd2, 16'd3);
    exp_q.push_back(5 + 5 + 6);
    step(4); step(5); step(6);
    exp_q.push_back(2 + 3 + 7);
    step(2); step(3); step(7);
    wr(2'd2, 16'd1);
    exp_q.push_back(4); step(3);
    exp_q.push_back(2); step(2);
    repeat (4) @(negedge clk);
    check("R6 all results delivered", exp_q.size(), 0);

    // R7
    wr(2'd2, 16'd0);
    step(2); step(2); step(2);
    repeat (3) @(negedge clk);
    check("R7 disabled no result", meas_valid, 0);

    // R8
    wr(2'd2, 16'd1);
    exp_q.push_back((5001 > 4095) ? 4095 : 5001);
    step(5000);
    repeat (4) @(negedge clk);
    check("R8 saturated delivered", exp_q.size(), 0);

    // R9
    @(negedge clk); meas_ready = 1'b0;
    wr(2'd2, 16'd1);
    step(3);
    step(2);
    repeat (2) @(negedge clk);
    check("R9 held valid", meas_valid, 1);
    check("R9 held data first", meas_data, 4);
    exp_q.push_back(4);
    @(negedge clk); meas_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 second result discarded", exp_q.size(), 0);
    check("R9 valid dropped", meas_valid, 0);

    // R10
    wr(2'd2, 16'd1);
    @(negedge clk); enc_a = ~enc_a; enc_b = ~enc_b;
    @(negedge clk);
    check("R10 fault_irq", fault_irq, 1);
    check("R10 fault_flag set", fault_flag, 1);
    @(negedge clk);
    check("R10 fault_irq one clock", fault_irq, 0);
    check("R10 fault not an edge", meas_valid, 0);
    // R11
    wr(2'd3, 16'd0);
    check("R11 clear with 0 ignored", fault_flag, 1);
    wr(2'd3, 16'd1);
    check("R11 cleared", fault_flag, 0);
    wr(2'd2, 16'd0);

    repeat (5) @(negedge clk);
    check("R6 scoreboard empty", exp_q.size(), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule